// File: doc/BRIEF.md
# SCSI Host Adapter Register Block and Command Decoder

This block is the host-side register interface of a small SCSI initiator controller. A processor reaches sixteen byte-wide registers through a simple address/data port with separate read and write strobes. A register index does not mean the same thing for reads and writes: the transfer counter, command and FIFO locations each have one view for writes and another for reads. Several reads have side effects. Reading the interrupt-cause register acknowledges the interrupt. Reading the FIFO location removes a byte from a 32-entry byte buffer.

Command bytes written to the command register are decoded. Housekeeping opcodes (FIFO flush, chip reset, bus reset) act inside the block. Bus-phase opcodes become one-cycle request strobes to the protocol sequencer. The top bit of every command byte selects DMA mode and copies the host-written transfer count into the count that the DMA engine uses. The sequencer reports back through a post port that loads status, interrupt cause and sequence step and can raise the interrupt line.

Top module: `hba_regfile`

## Requirements
- R1: The register index is address bits 5:2. Address bits 1:0 have no effect on any access.
- R2: After reset every register index reads 0x00, except index 14, which reads 0x04. `irq`, `dma_mode`, `cmd_req` and `xfer_count` are zero.
- R3: Indices 8, 12, 13, 14 and 15 read back the last byte written to them. Index 11 reads back the written byte ANDed with 0x15. Indices 9 and 10 always read 0x00.
- R4: A write to index 0 or 1 stores the low or high byte of the host transfer count and clears status bit 4. It does not change the readable count. A command byte with bit 7 set makes `dma_mode` 1 and copies the host count into `xfer_count` and into read indices 0 (low byte) and 1 (high byte). A command byte with bit 7 clear makes `dma_mode` 0 and leaves the readable count unchanged.
- R5: A write to index 2 appends a byte to the FIFO, and is dropped when 32 bytes are held. Index 7 reads the number of bytes held. A read of index 2 returns the oldest byte and removes it, but only when status bits 2:1 are not both zero and the FIFO is not empty. Otherwise the read returns 0x00 and the FIFO is unchanged.
- R6: Command opcode 0x01 (bits 6:0) empties the FIFO and sets cause to 0x08 and step to 0. It leaves `irq` unchanged.
- R7: Opcode 0x03 sets cause to 0x80. It raises `irq` unless bit 6 of index 8 is set.
- R8: Opcode 0x02 returns every register, the FIFO, `irq` and `dma_mode` to their reset values.
- R9: `cmd_req` is one-hot and is high only in the cycle after the command write. Bit 0 is opcode 0x10, bit 1 is 0x11, bit 2 is 0x12, bit 3 is 0x42 and bit 4 is 0x43. Opcode 0x12 also sets cause to 0x20 and step to 0.
- R10: Reading index 5 returns the cause byte, clears status bits 7, 6 and 5, and lowers `irq`.
- R11: Opcode 0x00 and any opcode not listed in R6 to R9 leave status, cause, step, `irq` and the FIFO unchanged and raise no strobe.
- R12: `seq_post` loads index 4 (status) from `seq_status`, index 5 (cause) from `seq_cause` and index 6 from `seq_step` (read as the low three bits). It raises `irq` when `seq_status` bit 7 is set. When a host access changes the same fields in the same cycle, the post takes effect instead; a chip reset overrides the post.
- R13: Index 3 reads the last command byte written, except after a chip reset, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address; bits 5:2 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request level |
| cmd_req | output | 5 | One-hot sequencer request strobes |
| dma_mode | output | 1 | DMA mode selected by the last command |
| xfer_count | output | 16 | Readable transfer count for the DMA engine |
| seq_post | input | 1 | Sequencer report strobe |
| seq_status | input | 8 | Status byte to load |
| seq_cause | input | 8 | Interrupt cause to load |
| seq_step | input | 3 | Sequence step to load |

## Verification
The assertions check several rules on every cycle: request strobes are one-hot and appear only after a command write, DMA mode follows bit 7 of the command byte, the FIFO count never exceeds its depth, pushes into a full FIFO are dropped, and the interrupt line follows the acknowledge read and sequencer posts. The bench scenarios cover the behaviour that needs data values: byte order through the FIFO across random fill levels, the read-back masks of the configuration registers, the reload of the readable count, the cause and step codes each opcode leaves behind, and the full return to reset values after a chip reset.

// File: rtl/hba_reg_pkg.sv
package hba_reg_pkg;

    localparam int XFER_W     = 16;
    localparam int STEP_W     = 3;
    localparam int NUM_STROBE = 5;
    localparam int UPPER_BASE = 12;
    localparam int NUM_UPPER  = 4;

    // Register indices (address bits 5:2)
    localparam logic [3:0] RI_CNT_LO = 4'd0;
    localparam logic [3:0] RI_CNT_HI = 4'd1;
    localparam logic [3:0] RI_FIFO   = 4'd2;
    localparam logic [3:0] RI_CMD    = 4'd3;
    localparam logic [3:0] RI_STAT   = 4'd4;
    localparam logic [3:0] RI_CAUSE  = 4'd5;
    localparam logic [3:0] RI_STEP   = 4'd6;
    localparam logic [3:0] RI_LEVEL  = 4'd7;
    localparam logic [3:0] RI_CFG_A  = 4'd8;
    localparam logic [3:0] RI_CFG_B  = 4'd11;
    localparam logic [3:0] RI_ID     = 4'd14;

    localparam logic [7:0] CFG_B_MASK = 8'h15;
    localparam int         CFG_A_QUIET_BIT = 6;

    // Opcodes (command bits 6:0)
    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_XFER    = 7'h10;
    localparam logic [6:0] OP_CPLT    = 7'h11;
    localparam logic [6:0] OP_MSGACC  = 7'h12;
    localparam logic [6:0] OP_SELATN  = 7'h42;
    localparam logic [6:0] OP_SELSTOP = 7'h43;

    // Strobe bit positions
    localparam int SB_XFER    = 0;
    localparam int SB_CPLT    = 1;
    localparam int SB_MSGACC  = 2;
    localparam int SB_SELATN  = 3;
    localparam int SB_SELSTOP = 4;

    // Cause codes
    localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
    localparam logic [7:0] CAUSE_DISC      = 8'h20;
    localparam logic [7:0] CAUSE_BUSRST    = 8'h80;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_FLUSH,
        ACT_CHIPRST,
        ACT_BUSRST,
        ACT_STROBE
    } cmd_act_e;

    typedef struct packed {
        logic                  dma;
        cmd_act_e              act;
        logic [NUM_STROBE-1:0] strobe;
        logic                  set_disc;
    } cmd_dec_t;

    typedef struct packed {
        logic       irq_pend;
        logic       gross_err;
        logic       parity_err;
        logic       count_zero;
        logic       spare;
        logic [2:0] phase;
    } stat_t;

    function automatic logic [3:0] reg_index(input logic [5:0] addr);
        return addr[5:2];
    endfunction

    function automatic cmd_dec_t decode_cmd(input logic [7:0] c);
        cmd_dec_t d;
        d.dma      = c[7];
        d.act      = ACT_NONE;
        d.strobe   = '0;
        d.set_disc = 1'b0;
        case (c[6:0])
            OP_FLUSH:   d.act = ACT_FLUSH;
            OP_CHIPRST: d.act = ACT_CHIPRST;
            OP_BUSRST:  d.act = ACT_BUSRST;
            OP_XFER: begin
                d.act = ACT_STROBE;
                d.strobe[SB_XFER] = 1'b1;
            end
            OP_CPLT: begin
                d.act = ACT_STROBE;
                d.strobe[SB_CPLT] = 1'b1;
            end
            OP_MSGACC: begin
                d.act = ACT_STROBE;
                d.strobe[SB_MSGACC] = 1'b1;
                d.set_disc = 1'b1;
            end
            OP_SELATN: begin
                d.act = ACT_STROBE;
                d.strobe[SB_SELATN] = 1'b1;
            end
            OP_SELSTOP: begin
                d.act = ACT_STROBE;
                d.strobe[SB_SELSTOP] = 1'b1;
            end
            default: d.act = ACT_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hba_byte_fifo.sv
module hba_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;
    logic [CNT_W-1:0] count_nx;

    assign do_push  = push && (count < CNT_W'(DEPTH));
    assign do_pop   = pop && (count != '0);
    assign count_nx = count + CNT_W'(do_push) - CNT_W'(do_pop);
    assign dout     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nx;
            if (count_nx == '0) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= bump(wr_ptr);
                if (do_pop)  rd_ptr <= bump(rd_ptr);
            end
        end
    end
endmodule

// File: rtl/hba_cmd_decode.sv
module hba_cmd_decode
    import hba_reg_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_dec_t   dec
);
    always_comb dec = decode_cmd(cmd_byte);
endmodule

// File: rtl/hba_read_mux.sv
module hba_read_mux
    import hba_reg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [3:0]        idx,
    input  logic [XFER_W-1:0] cnt_rd,
    input  logic [7:0]        fifo_val,
    input  logic [7:0]        cmd_q,
    input  stat_t             stat,
    input  logic [7:0]        cause,
    input  logic [STEP_W-1:0] step,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [7:0]        cfg_a,
    input  logic [7:0]        cfg_b,
    input  logic [7:0]        upper_sel,
    output logic [7:0]        rdata
);
    always_comb begin
        rdata = 8'h00;
        if (idx >= 4'(UPPER_BASE)) begin
            rdata = upper_sel;
        end else begin
            case (idx)
                RI_CNT_LO: rdata = cnt_rd[7:0];
                RI_CNT_HI: rdata = cnt_rd[15:8];
                RI_FIFO:   rdata = fifo_val;
                RI_CMD:    rdata = cmd_q;
                RI_STAT:   rdata = stat;
                RI_CAUSE:  rdata = cause;
                RI_STEP:   rdata = 8'(step);
                RI_LEVEL:  rdata = 8'(fifo_cnt);
                RI_CFG_A:  rdata = cfg_a;
                RI_CFG_B:  rdata = cfg_b;
                default:   rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
    import hba_reg_pkg::*;
#(
    parameter int         FIFO_DEPTH = 32,
    parameter int         ADDR_W     = 6,
    parameter logic [7:0] ID_VALUE   = 8'h04
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  irq,
    output logic [NUM_STROBE-1:0] cmd_req,
    output logic                  dma_mode,
    output logic [XFER_W-1:0]     xfer_count,
    input  logic                  seq_post,
    input  logic [7:0]            seq_status,
    input  logic [7:0]            seq_cause,
    input  logic [STEP_W-1:0]     seq_step
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [3:0]            idx;
    logic [XFER_W-1:0]     cnt_wr, cnt_rd;
    logic [7:0]            cmd_q, cause, cfg_a, cfg_b;
    stat_t                 stat;
    logic [STEP_W-1:0]     step;
    logic                  irq_q, dma_q;
    logic [NUM_STROBE-1:0] req_q;
    logic [7:0]            upper [NUM_UPPER];
    logic [7:0]            upper_sel;

    cmd_dec_t              dec;
    logic                  cmd_wr, soft_rst, fifo_flush, fifo_push, fifo_pop;
    logic [7:0]            fifo_head, fifo_val;
    logic [CNT_W-1:0]      fifo_cnt;
    logic                  cause_rd;

    assign idx      = reg_index(6'(bus_addr));
    assign cmd_wr   = bus_wr && (idx == RI_CMD);
    assign soft_rst = cmd_wr && (dec.act == ACT_CHIPRST);
    assign cause_rd = bus_rd && (idx == RI_CAUSE);

    // Only non-data phases move bytes through the host FIFO port
    assign fifo_pop   = bus_rd && (idx == RI_FIFO) && (stat.phase[2:1] != 2'b00)
                        && (fifo_cnt != '0);
    assign fifo_push  = bus_wr && (idx == RI_FIFO);
    assign fifo_flush = soft_rst || (cmd_wr && (dec.act == ACT_FLUSH));
    assign fifo_val   = fifo_pop ? fifo_head : 8'h00;

    hba_cmd_decode u_dec (
        .cmd_byte (bus_wdata),
        .dec      (dec)
    );

    hba_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_flush),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (bus_wdata),
        .dout  (fifo_head),
        .count (fifo_cnt)
    );

    // Free-form byte registers at the top of the map
    for (genvar g = 0; g < NUM_UPPER; g++) begin : g_upper
        localparam logic [3:0] MY_IDX = 4'(UPPER_BASE + g);
        localparam logic [7:0] RST_V  = (MY_IDX == RI_ID) ? ID_VALUE : 8'h00;
        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                upper[g] <= RST_V;
            else if (bus_wr && (idx == MY_IDX))
                upper[g] <= bus_wdata;
        end
    end

    assign upper_sel = upper[idx[1:0]];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt_wr <= '0;
            cnt_rd <= '0;
            cmd_q  <= '0;
            cause  <= '0;
            cfg_a  <= '0;
            cfg_b  <= '0;
            stat   <= '0;
            step   <= '0;
            irq_q  <= 1'b0;
            dma_q  <= 1'b0;
            req_q  <= '0;
        end else begin
            req_q <= '0;

            // Read side effect: acknowledge
            if (cause_rd) begin
                stat.irq_pend   <= 1'b0;
                stat.gross_err  <= 1'b0;
                stat.parity_err <= 1'b0;
                irq_q           <= 1'b0;
            end

            if (bus_wr) begin
                case (idx)
                    RI_CNT_LO: begin
                        cnt_wr[7:0]     <= bus_wdata;
                        stat.count_zero <= 1'b0;
                    end
                    RI_CNT_HI: begin
                        cnt_wr[15:8]    <= bus_wdata;
                        stat.count_zero <= 1'b0;
                    end
                    RI_CMD: begin
                        cmd_q <= bus_wdata;
                        dma_q <= dec.dma;
                        if (dec.dma) cnt_rd <= cnt_wr;
                        case (dec.act)
                            ACT_FLUSH: begin
                                cause <= CAUSE_FUNC_DONE;
                                step  <= '0;
                            end
                            ACT_BUSRST: begin
                                cause <= CAUSE_BUSRST;
                                if (!cfg_a[CFG_A_QUIET_BIT]) irq_q <= 1'b1;
                            end
                            ACT_STROBE: begin
                                req_q <= dec.strobe;
                                if (dec.set_disc) begin
                                    cause <= CAUSE_DISC;
                                    step  <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                    RI_CFG_A: cfg_a <= bus_wdata;
                    RI_CFG_B: cfg_b <= bus_wdata & CFG_B_MASK;
                    default: ;
                endcase
            end

            // Sequencer report has the last word
            if (seq_post) begin
                stat  <= stat_t'(seq_status);
                cause <= seq_cause;
                step  <= seq_step;
                if (seq_status[7]) irq_q <= 1'b1;
            end
        end
    end

    hba_read_mux #(.CNT_W(CNT_W)) u_rmux (
        .idx       (idx),
        .cnt_rd    (cnt_rd),
        .fifo_val  (fifo_val),
        .cmd_q     (cmd_q),
        .stat      (stat),
        .cause     (cause),
        .step      (step),
        .fifo_cnt  (fifo_cnt),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .upper_sel (upper_sel),
        .rdata     (bus_rdata)
    );

    assign irq        = irq_q;
    assign cmd_req    = req_q;
    assign dma_mode   = dma_q;
    assign xfer_count = cnt_rd;
endmodule

// File: rtl/hba_regfile_chk.sv
module hba_regfile_chk #(
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 6,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              seq_post,
    input logic [7:0]        seq_status,
    input logic              irq,
    input logic [4:0]        cmd_req,
    input logic              dma_mode,
    input logic [CNT_W-1:0]  fifo_cnt
);
    logic [3:0] ci;
    assign ci = bus_addr[5:2];

    assert_reset_quiet_R2: assert property (@(posedge clk)
        rst |=> (!irq && cmd_req == '0 && !dma_mode && fifo_cnt == '0));

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_req));

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_req != '0) |-> $past(bus_wr && ci == 4'd3));

    assert_dma_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ci == 4'd3 && bus_wdata[6:0] != 7'h02) |=> (dma_mode == $past(bus_wdata[7])));

    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CNT_W'(FIFO_DEPTH) && bus_wr && ci == 4'd2 && !bus_rd)
        |=> (fifo_cnt == CNT_W'(FIFO_DEPTH)));

    assert_ack_lowers_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ci == 4'd5 && !seq_post && !bus_wr) |=> !irq);

    assert_post_raises_R12: assert property (@(posedge clk) disable iff (rst)
        (seq_post && seq_status[7] && !bus_wr) |=> irq);
endmodule

bind hba_regfile hba_regfile_chk #(.FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .seq_post   (seq_post),
    .seq_status (seq_status),
    .irq        (irq),
    .cmd_req    (cmd_req),
    .dma_mode   (dma_mode),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/hba_regfile_test.sv
`timescale 1ns/1ps
module hba_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, dma_mode;
    logic [4:0]  cmd_req;
    logic [15:0] xfer_count;
    logic        seq_post = 1'b0;
    logic [7:0]  seq_status = '0, seq_cause = '0;
    logic [2:0]  seq_step = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hba_regfile uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmd_req(cmd_req),
        .dma_mode(dma_mode), .xfer_count(xfer_count), .seq_post(seq_post),
        .seq_status(seq_status), .seq_cause(seq_cause), .seq_step(seq_step)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Low address bits are randomised on every access (R1)
    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'($urandom % 4)};
        bus_wdata = d;
        bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'($urandom % 4)};
        bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic post(input logic [7:0] st, input logic [7:0] ca, input logic [2:0] sp);
        @(negedge clk);
        seq_status = st; seq_cause = ca; seq_step = sp; seq_post = 1'b1;
        @(posedge clk);
        #1 seq_post = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        rd(idx, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [7:0] reset_val(input int i);
        return (i == 14) ? 8'h04 : 8'h00;
    endfunction

    function automatic bit known_op(input logic [6:0] op);
        return op inside {7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12, 7'h42, 7'h43};
    endfunction

    function automatic logic [4:0] strobe_of(input logic [6:0] op);
        case (op)
            7'h10: return 5'b00001;
            7'h11: return 5'b00010;
            7'h12: return 5'b00100;
            7'h42: return 5'b01000;
            7'h43: return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q [$];
        logic [7:0] v, b;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset values
        for (int i = 0; i < 16; i++) rd_chk($sformatf("R2 idx%0d", i), 4'(i), reset_val(i));
        chk("R2 irq", irq, 0);
        chk("R2 cmd_req", cmd_req, 0);
        chk("R2 dma_mode", dma_mode, 0);
        chk("R2 xfer_count", xfer_count, 0);

        // R3 / R1: read-back and masks with random low address bits
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d8, d11, d12, d15;
            d8 = 8'($urandom); d11 = 8'($urandom); d12 = 8'($urandom); d15 = 8'($urandom);
            d8[6] = 1'b0;
            wr(8, d8); wr(11, d11); wr(12, d12); wr(15, d15); wr(9, 8'hFF); wr(10, 8'hA5);
            rd_chk("R3 cfg8 R1", 8, d8);
            rd_chk("R3 mask11", 11, d11 & 8'h15);
            rd_chk("R3 idx12", 12, d12);
            rd_chk("R3 idx15", 15, d15);
            rd_chk("R3 idx9 zero", 9, 8'h00);
            rd_chk("R3 idx10 zero", 10, 8'h00);
        end
        wr(14, 8'h5A);
        rd_chk("R3 idx14", 14, 8'h5A);
        wr(8, 8'h00);

        // R12: sequencer post
        post(8'h82, 8'h10, 3'd4);
        chk("R12 irq raised", irq, 1);
        rd_chk("R12 status", 4, 8'h82);
        rd_chk("R12 step", 6, 8'h04);
        // R10: acknowledge read
        rd_chk("R10 cause value", 5, 8'h10);
        chk("R10 irq lowered", irq, 0);
        rd_chk("R10 status cleared", 4, 8'h02);
        post(8'hF2, 8'h18, 3'd2);
        rd_chk("R10 cause 2", 5, 8'h18);
        rd_chk("R10 bits 7:5 cleared", 4, 8'h12);
        post(8'h02, 8'h00, 3'd0);
        chk("R12 no irq without bit7", irq, 0);

        // R5: random FIFO traffic in a non-data phase (status 0x02)
        for (int round = 0; round < 8; round++) begin
            int n;
            n = 1 + ($urandom % 20);
            for (int j = 0; j < n; j++) begin
                b = 8'($urandom);
                wr(2, b);
                q.push_back(b);
            end
            rd_chk("R5 level", 7, 8'(q.size()));
            while (q.size() > 0) rd_chk("R5 pop order", 2, q.pop_front());
            rd_chk("R5 level empty", 7, 8'h00);
        end
        for (int j = 0; j < 35; j++) begin
            b = 8'(j * 7 + 1);
            wr(2, b);
            if (j < 32) q.push_back(b);
        end
        rd_chk("R5 full level", 7, 8'd32);
        while (q.size() > 0) rd_chk("R5 full order", 2, q.pop_front());
        rd_chk("R5 empty read zero", 2, 8'h00);
        rd_chk("R5 empty level", 7, 8'h00);
        post(8'h00, 8'h00, 3'd0);
        wr(2, 8'hC3); wr(2, 8'h3C);
        rd_chk("R5 data phase read zero", 2, 8'h00);
        rd_chk("R5 data phase no pop", 7, 8'd2);

        // R6: flush
        post(8'h83, 8'h44, 3'd5);
        wr(3, 8'h01);
        rd_chk("R6 level", 7, 8'h00);
        rd_chk("R6 step", 6, 8'h00);
        chk("R6 irq unchanged", irq, 1);
        rd_chk("R6 cause", 5, 8'h08);
        post(8'h02, 8'h00, 3'd0);

        // R4: counter and DMA mode
        post(8'h12, 8'h00, 3'd0);
        wr(0, 8'h34);
        rd_chk("R4 tc cleared", 4, 8'h02);
        wr(1, 8'h12);
        rd_chk("R4 no reload yet", 0, 8'h00);
        wr(3, 8'h80);
        chk("R4 dma on", dma_mode, 1);
        chk("R4 xfer_count", xfer_count, 16'h1234);
        rd_chk("R4 cnt lo", 0, 8'h34);
        rd_chk("R4 cnt hi", 1, 8'h12);
        rd_chk("R13 cmd readback", 3, 8'h80);
        wr(0, 8'h55);
        rd_chk("R4 hold lo", 0, 8'h34);
        wr(3, 8'h00);
        chk("R4 dma off", dma_mode, 0);
        chk("R4 count kept", xfer_count, 16'h1234);
        wr(3, 8'h80);
        chk("R4 reload", xfer_count, 16'h1255);

        // R9: strobes
        begin
            logic [6:0] ops [5] = '{7'h10, 7'h11, 7'h12, 7'h42, 7'h43};
            foreach (ops[i]) begin
                logic [7:0] c;
                c = {1'($urandom), ops[i]};
                wr(3, c);
                chk("R9 strobe", cmd_req, strobe_of(ops[i]));
                @(posedge clk); #1;
                chk("R9 strobe one cycle", cmd_req, 0);
                rd_chk("R13 last command", 3, c);
            end
            rd_chk("R9 msgacc step", 6, 8'h00);
            rd_chk("R9 msgacc cause", 5, 8'h20);
        end

        // R7: bus reset with and without quiet bit
        wr(8, 8'h00);
        wr(3, 8'h03);
        chk("R7 irq raised", irq, 1);
        rd_chk("R7 cause", 5, 8'h80);
        wr(8, 8'h40);
        wr(3, 8'h03);
        chk("R7 irq masked", irq, 0);
        rd_chk("R7 cause masked", 5, 8'h80);

        // R11: unknown opcodes change nothing
        post(8'h86, 8'h21, 3'd3);
        wr(2, 8'h99);
        for (int k = 0; k < 10; k++) begin
            logic [6:0] op;
            do op = 7'($urandom); while (known_op(op));
            if (k == 0) op = 7'h00;
            wr(3, {1'b0, op});
            chk("R11 no strobe", cmd_req, 0);
        end
        chk("R11 irq", irq, 1);
        rd_chk("R11 status", 4, 8'h86);
        rd_chk("R11 step", 6, 8'h03);
        rd_chk("R11 level", 7, 8'h01);
        rd_chk("R11 cause", 5, 8'h21);

        // R8: chip reset
        wr(12, 8'hEE); wr(11, 8'hFF); wr(3, 8'h80);
        post(8'h87, 8'h01, 3'd1);
        wr(3, 8'h82);
        chk("R8 irq", irq, 0);
        chk("R8 dma", dma_mode, 0);
        chk("R8 xfer_count", xfer_count, 0);
        for (int i = 0; i < 16; i++) rd_chk($sformatf("R8 idx%0d", i), 4'(i), reset_val(i));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule